// File: doc/BRIEF.md
# Configuration-Space Serial EEPROM Port with Image Checksum Checker

This block lets host software bit-bang a three-wire serial EEPROM (chip select, clock, data in, plus a data-out return line) purely through configuration-space accesses. A write to one reserved config offset raises chip select and drives the clock and data-in lines from two bits of the written byte. A write to a second reserved offset drops all three lines. Both of these writes are consumed by the block. Every other write passes through unchanged to the normal configuration space. The data-out line is returned by gating a single-byte read of config offset 0. When data-out is low, that byte reads as zero.

A companion checker validates an EEPROM image. After a start pulse it fetches the 64 little-endian 16-bit words of the image, one per cycle, through a word-read port. Word k is formed from byte 2k as the low half and byte 2k+1 as the high half. The checker adds the words with 16-bit wrap-around. The image is valid when the total equals 0x1234. This holds because the last word, bytes 126 (low) and 127 (high), stores 0x1234 minus the sum of the first 63 words. A typical image carries the adapter SCSI ID at byte 64 (default 7), a mode byte at 65 (default 0x0F), a tag command count at 67 (default 4) and an options byte at 68. The option bits are: bit 0 boot hotkeys, bit 1 boot from CD, bit 2 disk BIOS services, bit 3 SCAM.

Top module: `eecfg_port`

## Requirements
- R1: A write to config offset 0x80 sets `ee_cs_o` to 1, `ee_sk_o` to write-data bit 7 and `ee_di_o` to write-data bit 6, visible from the clock edge that accepts the write.
- R2: A write to config offset 0xC0 drives `ee_cs_o`, `ee_sk_o` and `ee_di_o` all to 0 from the accepting edge.
- R3: After reset the three pin outputs are 0. Between writes to 0x80 or 0xC0 they hold their last value; writes to any other offset leave them unchanged.
- R4: A write to any offset other than 0x80 and 0xC0 is forwarded in the same cycle on `base_wr_o`, with address and data unchanged. Writes to 0x80 and 0xC0 are not forwarded.
- R5: A read with `cfg_byte_i`=1 at offset 0 returns `base_rdata_i` when `ee_do_i`=1. When `ee_do_i`=0 it returns the same value with bits 7:0 forced to 0x00.
- R6: Any other read is `base_rdata_i` unchanged, whatever `ee_do_i` is. This covers a full-width read at offset 0 and a byte read at any other offset.
- R7: A `chk_start_i` pulse while idle raises `chk_busy_o` at the next edge. `word_addr_o` then presents 0, 1, …, 63, one word per cycle, in ascending order.
- R8: The edge after word 63 is consumed does three things. It clears `chk_busy_o`, pulses `chk_done_o` for exactly one cycle, and loads `chk_sum_o` with the 16-bit wrap-around sum of the 64 words.
- R9: `chk_valid_o` is 1 after a run exactly when that sum equals 0x1234. It holds until the next accepted start, which clears it.
- R10: `chk_start_i` is ignored while `chk_busy_o` is 1: the word sequence continues without restarting.
- R11: After reset `chk_busy_o`, `chk_done_o` and `chk_valid_o` are 0 and `chk_sum_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 8 | Config byte offset of the access |
| cfg_wdata_i | input | 32 | Config write data |
| cfg_byte_i | input | 1 | Access is a single byte |
| base_wr_o | output | 1 | Forwarded write strobe to normal config space |
| base_addr_o | output | 8 | Forwarded write offset |
| base_wdata_o | output | 32 | Forwarded write data |
| base_rdata_i | input | 32 | Read data from normal config space |
| cfg_rdata_o | output | 32 | Read data returned to host |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | EEPROM data in |
| ee_do_i | input | 1 | EEPROM data out |
| chk_start_i | input | 1 | Start an image check |
| word_addr_o | output | 6 | Word index requested from the image |
| word_data_i | input | 16 | Word at `word_addr_o` (low byte = even byte) |
| chk_busy_o | output | 1 | Check in progress |
| chk_done_o | output | 1 | One-cycle pulse at the end of a check |
| chk_valid_o | output | 1 | Image sum matched 0x1234 |
| chk_sum_o | output | 16 | Sum of the last completed check |

## Verification
The bench targets the boundaries of the read gate. These are a byte read at offset 0 with data-out low, a full-width read at offset 0 and a byte read at offset 1. A design that decodes address or size loosely would zero the wrong reads, or fail to zero the right one. It checks that the two reserved writes never reach normal config space and that other writes never move the pins. A leaky decode shows up as a spurious `base_wr_o` or a pin glitch. For the checker it checks the word sequence, the one-cycle done pulse and the result for a correct image and for an image with one corrupted byte. It also pulses start in mid-run. A design that restarted, stopped one word early or miscounted the last word would report the wrong sum or a wrong valid flag.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] PIN_OFS  = 8'h80;
  localparam logic [ADDR_W-1:0] DROP_OFS = 8'hC0;
  localparam logic [ADDR_W-1:0] GATE_OFS = 8'h00;
  localparam int SK_BIT = 7;
  localparam int DI_BIT = 6;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ee_pins_t;
endpackage

// File: rtl/eecfg_pin_ctl.sv
module eecfg_pin_ctl
  import eecfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PIN_A  = PIN_OFS,
  parameter logic [ADDR_W-1:0] DROP_A = DROP_OFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sk_bit_i,
  input  logic              di_bit_i,
  output logic              claim_o,
  output ee_pins_t          pins_o
);
  logic hit_pin, hit_drop;
  assign hit_pin  = wr_i && (addr_i == PIN_A);
  assign hit_drop = wr_i && (addr_i == DROP_A);
  assign claim_o  = hit_pin || hit_drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= '0;
    end else if (hit_pin) begin
      pins_o.cs <= 1'b1;
      pins_o.sk <= sk_bit_i;
      pins_o.di <= di_bit_i;
    end else if (hit_drop) begin
      pins_o <= '0;
    end
  end

  AST_PIN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == PIN_A) |=> (pins_o.cs && pins_o.sk == $past(sk_bit_i) && pins_o.di == $past(di_bit_i))); // R1
  AST_PIN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == DROP_A) |=> (pins_o == '0)); // R2
  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == PIN_A || addr_i == DROP_A)) |=> $stable(pins_o)); // R3
endmodule

// File: rtl/eecfg_rd_gate.sv
module eecfg_rd_gate
  import eecfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GATE_A = GATE_OFS
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic              ee_do_i,
  input  logic [DATA_W-1:0] base_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic zero_lo;
  assign zero_lo = byte_i && (addr_i == GATE_A) && !ee_do_i;

  always_comb begin
    rdata_o = base_rdata_i;
    if (zero_lo) rdata_o[7:0] = 8'h00;
  end

  always_comb begin
    if (!(byte_i && addr_i == GATE_A)) begin
      AST_RD_PASS: assert (rdata_o == base_rdata_i); // R6
    end
    AST_RD_UPPER: assert (rdata_o[DATA_W-1:8] == base_rdata_i[DATA_W-1:8]); // R5
  end
endmodule

// File: rtl/eecfg_sum_chk.sv
module eecfg_sum_chk #(
  parameter int           WORDS  = 64,
  parameter int           SUM_W  = 16,
  parameter logic [15:0]  TARGET = 16'h1234,
  localparam int          CNT_W  = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] word_addr_o,
  input  logic [SUM_W-1:0] word_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [SUM_W-1:0] sum_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] acc_q, acc_nx;
  logic             last;

  assign last        = (cnt_q == CNT_W'(WORDS - 1));
  assign acc_nx      = acc_q + word_data_i;
  assign word_addr_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o  <= 1'b1;
          cnt_q   <= '0;
          acc_q   <= '0;
          valid_o <= 1'b0;
        end
      end else begin
        acc_q <= acc_nx;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          sum_o   <= acc_nx;
          valid_o <= (acc_nx == SUM_W'(TARGET));
        end
      end
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && word_addr_o == '0)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> (busy_o && word_addr_o == $past(word_addr_o) + 1'b1)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last) |=> (done_o && !busy_o)); // R8
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(valid_o)); // R9
endmodule

// File: rtl/eecfg_port.sv
module eecfg_port
  import eecfg_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int CNT_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              cfg_byte_i,
  output logic              base_wr_o,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [DATA_W-1:0] base_wdata_o,
  input  logic [DATA_W-1:0] base_rdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i,
  input  logic              chk_start_i,
  output logic [CNT_W-1:0]  word_addr_o,
  input  logic [15:0]       word_data_i,
  output logic              chk_busy_o,
  output logic              chk_done_o,
  output logic              chk_valid_o,
  output logic [15:0]       chk_sum_o
);
  ee_pins_t pins;
  logic     claim;

  eecfg_pin_ctl i_pin_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .addr_i   (cfg_addr_i),
    .sk_bit_i (cfg_wdata_i[SK_BIT]),
    .di_bit_i (cfg_wdata_i[DI_BIT]),
    .claim_o  (claim),
    .pins_o   (pins)
  );

  assign ee_cs_o = pins.cs;
  assign ee_sk_o = pins.sk;
  assign ee_di_o = pins.di;

  assign base_wr_o    = cfg_wr_i && !claim;
  assign base_addr_o  = cfg_addr_i;
  assign base_wdata_o = cfg_wdata_i;

  eecfg_rd_gate i_rd_gate (
    .addr_i       (cfg_addr_i),
    .byte_i       (cfg_byte_i),
    .ee_do_i      (ee_do_i),
    .base_rdata_i (base_rdata_i),
    .rdata_o      (cfg_rdata_o)
  );

  eecfg_sum_chk #(.WORDS(WORDS), .SUM_W(16), .TARGET(16'h1234)) i_sum_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (chk_start_i),
    .word_addr_o (word_addr_o),
    .word_data_i (word_data_i),
    .busy_o      (chk_busy_o),
    .done_o      (chk_done_o),
    .valid_o     (chk_valid_o),
    .sum_o       (chk_sum_o)
  );

  AST_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && (cfg_addr_i == PIN_OFS || cfg_addr_i == DROP_OFS)) |-> !base_wr_o); // R4
endmodule

// File: tb/test_eecfg_port.sv
module test_eecfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_byte = 1'b0;
  logic        base_wr;
  logic [7:0]  base_addr;
  logic [31:0] base_wdata;
  logic [31:0] base_rdata = '0;
  logic [31:0] cfg_rdata;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic        chk_start = 1'b0;
  logic [5:0]  word_addr;
  logic [15:0] word_data;
  logic        chk_busy, chk_done, chk_valid;
  logic [15:0] chk_sum;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [128];

  always #4 clk = ~clk;

  assign word_data = {img[2*word_addr+1], img[2*word_addr]};

  eecfg_port i_eecfg_port (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_byte_i(cfg_byte),
    .base_wr_o(base_wr), .base_addr_o(base_addr), .base_wdata_o(base_wdata),
    .base_rdata_i(base_rdata), .cfg_rdata_o(cfg_rdata),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do),
    .chk_start_i(chk_start), .word_addr_o(word_addr), .word_data_i(word_data),
    .chk_busy_o(chk_busy), .chk_done_o(chk_done), .chk_valid_o(chk_valid), .chk_sum_o(chk_sum)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic fwd_exp, input string req);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    #1;
    check(req, {31'd0, base_wr}, {31'd0, fwd_exp});
    if (fwd_exp) begin
      check(req, {24'd0, base_addr}, {24'd0, a});
      check(req, base_wdata, d);
    end
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [15:0] img_sum();
    logic [15:0] s = '0;
    for (int k = 0; k < 64; k++) s = s + {img[2*k+1], img[2*k]};
    return s;
  endfunction

  task automatic build_image();
    logic [15:0] s = '0;
    for (int i = 0; i < 128; i++) img[i] = 8'h00;
    for (int i = 0; i < 16; i++) img[2*i] = 8'h57;
    img[64] = 8'd7; img[65] = 8'h0F; img[67] = 8'h04; img[68] = 8'h07;
    for (int k = 0; k < 63; k++) s = s + {img[2*k+1], img[2*k]};
    s = 16'h1234 - s;
    img[126] = s[7:0]; img[127] = s[15:8];
  endtask

  task automatic t_reset();
    check("R3 reset pins", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    check("R11 reset busy/done/valid", {29'd0, chk_busy, chk_done, chk_valid}, 32'd0);
    check("R11 reset sum", {16'd0, chk_sum}, 32'd0);
  endtask

  task automatic t_pins();
    do_write(8'h80, 32'h0000_00C0, 1'b0, "R4 no fwd 0x80");
    check("R1 cs/sk/di=1,1,1", {29'd0, ee_cs, ee_sk, ee_di}, 32'd7);
    do_write(8'h80, 32'h0000_0040, 1'b0, "R4 no fwd 0x80");
    check("R1 cs/sk/di=1,0,1", {29'd0, ee_cs, ee_sk, ee_di}, 32'd5);
    do_write(8'h80, 32'h0000_0080, 1'b0, "R4 no fwd 0x80");
    check("R1 cs/sk/di=1,1,0", {29'd0, ee_cs, ee_sk, ee_di}, 32'd6);
    do_write(8'h84, 32'hFFFF_FFFF, 1'b1, "R4 fwd 0x84");
    check("R3 hold after other write", {29'd0, ee_cs, ee_sk, ee_di}, 32'd6);
    repeat (3) @(negedge clk);
    check("R3 hold idle", {29'd0, ee_cs, ee_sk, ee_di}, 32'd6);
    do_write(8'hC0, 32'hFFFF_FFFF, 1'b0, "R4 no fwd 0xC0");
    check("R2 drop", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    do_write(8'h00, 32'h0000_00C0, 1'b1, "R4 fwd 0x00");
    check("R3 unchanged by 0x00", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
  endtask

  task automatic t_reads();
    @(negedge clk);
    base_rdata = 32'hA5C3_7E91;
    cfg_addr = 8'h00; cfg_byte = 1'b1; ee_do = 1'b0; #1;
    check("R5 byte@0 do=0", cfg_rdata, 32'hA5C3_7E00);
    ee_do = 1'b1; #1;
    check("R5 byte@0 do=1", cfg_rdata, 32'hA5C3_7E91);
    ee_do = 1'b0; cfg_byte = 1'b0; #1;
    check("R6 word@0 do=0", cfg_rdata, 32'hA5C3_7E91);
    cfg_addr = 8'h01; cfg_byte = 1'b1; #1;
    check("R6 byte@1 do=0", cfg_rdata, 32'hA5C3_7E91);
    cfg_addr = 8'h00; base_rdata = 32'h0000_00FF; #1;
    check("R5 byte@0 do=0 b", cfg_rdata, 32'h0000_0000);
    cfg_byte = 1'b0; cfg_addr = 8'h00;
  endtask

  task automatic run_check(input string tag, input logic [15:0] exp_sum, input int restart_at);
    @(negedge clk);
    chk_start = 1'b1;
    @(negedge clk);
    chk_start = 1'b0;
    check({tag, " R7 busy"}, {31'd0, chk_busy}, 32'd1);
    check({tag, " R9 valid cleared"}, {31'd0, chk_valid}, 32'd0);
    for (int k = 0; k < 64; k++) begin
      if (word_addr !== 6'(k)) check({tag, " R7 addr seq"}, {26'd0, word_addr}, k);
      if (k == restart_at) chk_start = 1'b1;
      @(negedge clk);
      chk_start = 1'b0;
      if (k == restart_at) check({tag, " R10 no restart"}, {26'd0, word_addr}, k + 1);
    end
    checks++;
    check({tag, " R8 done"}, {30'd0, chk_done, chk_busy}, 32'd2);
    check({tag, " R8 sum"}, {16'd0, chk_sum}, {16'd0, exp_sum});
    check({tag, " R9 valid"}, {31'd0, chk_valid}, {31'd0, exp_sum == 16'h1234});
    @(negedge clk);
    check({tag, " R8 done pulse"}, {31'd0, chk_done}, 32'd0);
    check({tag, " R9 valid hold"}, {31'd0, chk_valid}, {31'd0, exp_sum == 16'h1234});
  endtask

  initial begin
    build_image();
    #1;
    t_reset();
    #20 rst_n = 1'b1;
    t_pins();
    t_reads();
    run_check("good", img_sum(), -1);
    img[70] = img[70] ^ 8'h10;
    run_check("corrupt", img_sum(), -1);
    img[70] = img[70] ^ 8'h10;
    run_check("restart", img_sum(), 20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule